// File: doc/BRIEF.md
# Sample Stream Serializer

This block turns a stream of quantized receiver samples into a one-bit serial data stream for a baseband processor. Each strobed sample carries a two-bit in-phase value and a two-bit quadrature value. A lane mode decides which of those bits are kept. The kept bits are packed into 16-bit slices, and the slices are queued in a short FIFO. A shifter then drains them, most significant bit first, one bit for each serial clock enable. The serial enable must run several times faster than the sample strobe.

Slices are grouped into frames of a fixed number of data slices. When stamping is on, the shifter places a 16-bit frame number ahead of the first data slice of each frame. A data-sync marker flags the first bit of every slice sent. A time-sync marker fires once every programmable number of accepted samples. Each marker has its own enable. Start and stop controls gate sample intake, and a stream-reset control returns the whole path to its empty state.

Top module: `sample_stream_ser`

## Requirements
- R1: With lane mode 1, each accepted sample adds its I MSB then its I LSB to the slice being built. Eight samples make one slice, and the first sample lands in bits 15:14. With lane mode 3, each sample adds the nibble {I MSB, I LSB, Q MSB, Q LSB}, so four samples make one slice. Slices leave on `sdata` MSB first, one bit for each `bit_en` cycle, in the order they were completed.
- R2: Lane modes 0 and 2 are reserved. A sample strobed while either one is selected changes neither the slice under construction nor the output stream.
- R3: If a slice completes while the FIFO holds FIFO_DEPTH slices, that slice is dropped and `ovf` goes high. `ovf` stays high until a stream reset or a reset.
- R4: When `dsync_en` is high at the moment a slice is loaded, `dsync` is high for that slice's first bit only. `dsync` is low for every other bit. When no slice is waiting, idle bits are sent with `sdata` low and `dsync` low.
- R5: A frame is FRAME_SLICES data slices. A 16-bit frame number starts at 0 and increments after each frame. When `stamp_en` is high, the frame number is sent as a slice just before the first data slice of each frame. When `stamp_en` is low, only data slices are sent.
- R6: While streaming, `tsync` is high for one clock in the cycle after every `tsync_period`-th accepted sample strobe, provided `tsync_en` is high. `tsync_period` may range from 128 to 16384. The period count keeps running while `tsync_en` is low.
- R7: A pulse on `start` enables sample intake from the next cycle on. A pulse on `stop` halts intake and the period count, but slices already queued continue to drain. If both are pulsed together, stop wins.
- R8: A `srst` pulse empties the FIFO and the partial slice. It also clears the frame number, frame position, period count and `ovf`, and stops streaming. All outputs are low in the following cycle.
- R9: After `rst_n` is released, all outputs are low and nothing streams until `start` is pulsed.
- R10: `sdata` and `dsync` change only at clock edges where `bit_en` is high (or where `srst` is high). Otherwise they hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the whole block |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | One-cycle strobe for each new sample |
| smp_i | input | 2 | In-phase sample bits {MSB, LSB} |
| smp_q | input | 2 | Quadrature sample bits {MSB, LSB} |
| lane_sel | input | 2 | Lane mode: 1 = I only, 3 = I and Q, 0/2 reserved |
| stamp_en | input | 1 | Insert a frame-number slice at each frame start |
| dsync_en | input | 1 | Enable the data-sync marker |
| tsync_en | input | 1 | Enable the time-sync marker |
| tsync_period | input | 15 | Accepted samples per time-sync pulse |
| start | input | 1 | Pulse to begin sample intake |
| stop | input | 1 | Pulse to halt sample intake |
| srst | input | 1 | Pulse to clear the stream state |
| bit_en | input | 1 | Serial bit enable: one output bit per high cycle |
| sdata | output | 1 | Serial data bit |
| dsync | output | 1 | First-bit marker of each slice |
| tsync | output | 1 | Periodic time-sync pulse |
| ovf | output | 1 | Sticky FIFO overflow flag |

## Verification
The bench sets FIFO_DEPTH to 4 and FRAME_SLICES to 4, keeping the other defaults. With a queue that shallow, strobing a sample every clock in lane mode 3 overflows the FIFO within a few dozen cycles. A four-slice frame means stamp slices, frame-number increments and the frame-position wrap all occur many times in a short run. Time-sync periods of 128 and 200 let several pulses arrive within a run of a few thousand cycles.

// File: rtl/sss_pkg.sv
package sss_pkg;
    localparam int SLICE_W = 16;
    localparam int NB_W    = $clog2(SLICE_W) + 1;

    typedef enum logic [1:0] {
        LANE_RSV0 = 2'd0,
        LANE_I    = 2'd1,
        LANE_RSV2 = 2'd2,
        LANE_IQ   = 2'd3
    } lane_e;
endpackage

// File: rtl/sss_packer.sv
module sss_packer
    import sss_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               take_i,
    input  logic [1:0]         lane_i,
    input  logic [1:0]         i_bits_i,
    input  logic [1:0]         q_bits_i,
    input  logic               fifo_full_i,
    output logic               push_o,
    output logic [SLICE_W-1:0] word_o,
    output logic               ovf_o
);
    typedef struct packed {
        logic [SLICE_W-1:0] acc;
        logic [NB_W-1:0]    nbits;
        logic               ovf;
    } pk_t;

    pk_t st_d, st_q;
    logic [SLICE_W-1:0] nacc;
    logic [NB_W-1:0]    nb;
    logic               lane_ok;

    assign lane_ok = (lane_i == LANE_I) || (lane_i == LANE_IQ);

    always_comb begin
        st_d   = st_q;
        push_o = 1'b0;
        word_o = '0;
        nacc   = st_q.acc;
        nb     = st_q.nbits;
        if (clr_i) begin
            st_d = '0;
        end else if (take_i && lane_ok) begin
            if (lane_i == LANE_I) begin
                nacc = {st_q.acc[SLICE_W-3:0], i_bits_i};
                nb   = st_q.nbits + NB_W'(2);
            end else begin
                nacc = {st_q.acc[SLICE_W-5:0], i_bits_i, q_bits_i};
                nb   = st_q.nbits + NB_W'(4);
            end
            if (nb >= NB_W'(SLICE_W)) begin
                word_o     = nacc;
                push_o     = !fifo_full_i;
                st_d.ovf   = st_q.ovf | fifo_full_i;
                st_d.acc   = '0;
                st_d.nbits = '0;
            end else begin
                st_d.acc   = nacc;
                st_d.nbits = nb;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ovf_o = st_q.ovf;

    assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !clr_i) |=> ovf_o);

    assert_reserved_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !clr_i && !lane_ok) |=> $stable(st_q.nbits));
endmodule

// File: rtl/sss_fifo.sv
module sss_fifo
    import sss_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               push_i,
    input  logic [SLICE_W-1:0] data_i,
    input  logic               pop_i,
    output logic [SLICE_W-1:0] head_o,
    output logic               empty_o,
    output logic               full_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][SLICE_W-1:0] mem;
        logic [AW-1:0]                 wp;
        logic [AW-1:0]                 rp;
        logic [CW-1:0]                 cnt;
    } ff_t;

    ff_t st_d, st_q;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end else begin
            if (push_i) begin
                st_d.mem[st_q.wp] = data_i;
                st_d.wp           = nxt(st_q.wp);
            end
            if (pop_i) st_d.rp = nxt(st_q.rp);
            st_d.cnt = st_q.cnt + CW'(push_i) - CW'(pop_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_o  = st_q.mem[st_q.rp];
    assign empty_o = (st_q.cnt == '0);
    assign full_o  = (st_q.cnt == CW'(DEPTH));

    assert_fifo_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));

    assert_no_push_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);

    assert_no_pop_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);
endmodule

// File: rtl/sss_shifter.sv
module sss_shifter
    import sss_pkg::*;
#(
    parameter int FRAME_SLICES = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               bit_en_i,
    input  logic               empty_i,
    input  logic [SLICE_W-1:0] head_i,
    input  logic               stamp_en_i,
    input  logic               dsync_en_i,
    output logic               pop_o,
    output logic               sdata_o,
    output logic               dsync_o
);
    localparam int FCW = (FRAME_SLICES > 1) ? $clog2(FRAME_SLICES) : 1;
    localparam int LW  = $clog2(SLICE_W);

    typedef struct packed {
        logic [SLICE_W-1:0] sh;
        logic [LW-1:0]      left;
        logic [FCW-1:0]     slc;
        logic [15:0]        fnum;
        logic               stamped;
        logic               sdata;
        logic               dsync;
    } sh_t;

    sh_t st_d, st_q;
    logic [SLICE_W-1:0] word;

    always_comb begin
        st_d  = st_q;
        pop_o = 1'b0;
        word  = '0;
        if (clr_i) begin
            st_d = '0;
        end else if (bit_en_i) begin
            if (st_q.left != '0) begin
                st_d.sdata = st_q.sh[SLICE_W-1];
                st_d.dsync = 1'b0;
                st_d.sh    = {st_q.sh[SLICE_W-2:0], 1'b0};
                st_d.left  = st_q.left - LW'(1);
            end else if (!empty_i) begin
                if ((st_q.slc == '0) && stamp_en_i && !st_q.stamped) begin
                    word         = st_q.fnum;
                    st_d.stamped = 1'b1;
                end else begin
                    word  = head_i;
                    pop_o = 1'b1;
                    if (st_q.slc == FCW'(FRAME_SLICES - 1)) begin
                        st_d.slc     = '0;
                        st_d.fnum    = st_q.fnum + 16'd1;
                        st_d.stamped = 1'b0;
                    end else begin
                        st_d.slc = st_q.slc + FCW'(1);
                    end
                end
                st_d.sdata = word[SLICE_W-1];
                st_d.dsync = dsync_en_i;
                st_d.sh    = {word[SLICE_W-2:0], 1'b0};
                st_d.left  = LW'(SLICE_W - 1);
            end else begin
                st_d.sdata = 1'b0;
                st_d.dsync = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdata_o = st_q.sdata;
    assign dsync_o = st_q.dsync;

    assert_dsync_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en_i && !clr_i && (st_q.left != '0)) |=> !dsync_o);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en_i && !clr_i) |=> ($stable(sdata_o) && $stable(dsync_o)));
endmodule

// File: rtl/sss_tsync.sv
module sss_tsync #(
    parameter int PW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          tick_i,
    input  logic          en_i,
    input  logic [PW-1:0] period_i,
    output logic          tsync_o
);
    typedef struct packed {
        logic [PW-1:0] cnt;
        logic          pulse;
    } ts_t;

    ts_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (clr_i) begin
            st_d = '0;
        end else if (tick_i) begin
            if (st_q.cnt >= period_i - PW'(1)) begin
                st_d.cnt   = '0;
                st_d.pulse = en_i;
            end else begin
                st_d.cnt = st_q.cnt + PW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tsync_o = st_q.pulse;

    assert_tsync_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tsync_o |=> !tsync_o);

    assert_tsync_after_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tsync_o |-> $past(tick_i));
endmodule

// File: rtl/sample_stream_ser.sv
module sample_stream_ser
    import sss_pkg::*;
#(
    parameter int FIFO_DEPTH   = 8,
    parameter int FRAME_SLICES = 32,
    parameter int PERIOD_W     = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_stb,
    input  logic [1:0]          smp_i,
    input  logic [1:0]          smp_q,
    input  logic [1:0]          lane_sel,
    input  logic                stamp_en,
    input  logic                dsync_en,
    input  logic                tsync_en,
    input  logic [PERIOD_W-1:0] tsync_period,
    input  logic                start,
    input  logic                stop,
    input  logic                srst,
    input  logic                bit_en,
    output logic                sdata,
    output logic                dsync,
    output logic                tsync,
    output logic                ovf
);
    logic active_d, active_q;
    logic take;
    logic push, pop, empty, full;
    logic [SLICE_W-1:0] push_word, head;

    always_comb begin
        active_d = active_q;
        if (srst || stop) active_d = 1'b0;
        else if (start)   active_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) active_q <= 1'b0;
        else        active_q <= active_d;
    end

    assign take = smp_stb && active_q;

    sss_packer u_packer (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (srst),
        .take_i      (take),
        .lane_i      (lane_sel),
        .i_bits_i    (smp_i),
        .q_bits_i    (smp_q),
        .fifo_full_i (full),
        .push_o      (push),
        .word_o      (push_word),
        .ovf_o       (ovf)
    );

    sss_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (srst),
        .push_i  (push),
        .data_i  (push_word),
        .pop_i   (pop),
        .head_o  (head),
        .empty_o (empty),
        .full_o  (full)
    );

    sss_shifter #(.FRAME_SLICES(FRAME_SLICES)) u_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (srst),
        .bit_en_i   (bit_en),
        .empty_i    (empty),
        .head_i     (head),
        .stamp_en_i (stamp_en),
        .dsync_en_i (dsync_en),
        .pop_o      (pop),
        .sdata_o    (sdata),
        .dsync_o    (dsync)
    );

    sss_tsync #(.PW(PERIOD_W)) u_tsync (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (srst),
        .tick_i   (take),
        .en_i     (tsync_en),
        .period_i (tsync_period),
        .tsync_o  (tsync)
    );

    assert_srst_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!sdata && !dsync && !tsync && !ovf));

    assert_idle_no_tsync_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_q) |=> !tsync);
endmodule

// File: tb/sample_stream_ser_tb_top.sv
`timescale 1ns/1ps
module sample_stream_ser_tb_top;
    localparam int DEPTH = 4;
    localparam int FR    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stb = 1'b0, stamp_en = 1'b0, dsync_en = 1'b0, tsync_en = 1'b0;
    logic start = 1'b0, stop = 1'b0, srst = 1'b0, bit_en = 1'b0;
    logic [1:0] si = 2'd0, sq = 2'd0, lane = 2'd0;
    logic [14:0] period = 15'd128;
    logic sdata, dsync, tsync, ovf;

    int n_chk = 0;
    int n_bad = 0;
    string tag = "R9";
    bit done = 1'b0;

    always #2 clk = ~clk;

    sample_stream_ser #(.FIFO_DEPTH(DEPTH), .FRAME_SLICES(FR), .PERIOD_W(15)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_stb(stb), .smp_i(si), .smp_q(sq),
        .lane_sel(lane), .stamp_en(stamp_en), .dsync_en(dsync_en),
        .tsync_en(tsync_en), .tsync_period(period), .start(start),
        .stop(stop), .srst(srst), .bit_en(bit_en), .sdata(sdata),
        .dsync(dsync), .tsync(tsync), .ovf(ovf)
    );

    // Behavioural reference model
    logic [15:0] m_q[$];
    int m_acc, m_nb, m_sh, m_left, m_slc, m_fnum, m_tcnt, sz0, w;
    bit m_ovf, m_stamped, m_active, e_sdata, e_dsync, e_tsync;

    task automatic m_clear();
        m_q.delete();
        m_acc = 0; m_nb = 0; m_sh = 0; m_left = 0; m_slc = 0; m_fnum = 0;
        m_tcnt = 0; m_ovf = 0; m_stamped = 0; m_active = 0;
        e_sdata = 0; e_dsync = 0; e_tsync = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n || srst) begin
            m_clear();
        end else begin
            sz0 = m_q.size();
            if (bit_en) begin
                if (m_left != 0) begin
                    e_sdata = m_sh[15]; e_dsync = 0;
                    m_sh = (m_sh << 1) & 16'hFFFF; m_left--;
                end else if (m_q.size() > 0) begin
                    if (m_slc == 0 && stamp_en && !m_stamped) begin
                        w = m_fnum; m_stamped = 1;
                    end else begin
                        w = m_q.pop_front();
                        m_slc++;
                        if (m_slc == FR) begin
                            m_slc = 0; m_fnum = (m_fnum + 1) & 16'hFFFF; m_stamped = 0;
                        end
                    end
                    e_sdata = w[15]; e_dsync = dsync_en;
                    m_sh = (w << 1) & 16'hFFFF; m_left = 15;
                end else begin
                    e_sdata = 0; e_dsync = 0;
                end
            end
            e_tsync = 0;
            if (stb && m_active) begin
                if (lane == 2'd1 || lane == 2'd3) begin
                    if (lane == 2'd1) begin m_acc = ((m_acc << 2) | si) & 16'hFFFF; m_nb += 2; end
                    else begin m_acc = ((m_acc << 4) | {si, sq}) & 16'hFFFF; m_nb += 4; end
                    if (m_nb >= 16) begin
                        if (sz0 >= DEPTH) m_ovf = 1;
                        else m_q.push_back(m_acc[15:0]);
                        m_acc = 0; m_nb = 0;
                    end
                end
                if (m_tcnt >= period - 1) begin m_tcnt = 0; e_tsync = tsync_en; end
                else m_tcnt++;
            end
            if (stop) m_active = 0;
            else if (start) m_active = 1;
        end
    end

    task automatic chk(input string nm, input logic g, input logic e);
        n_chk++;
        if (g !== e) begin
            n_bad++;
            $display("FAIL %s %s got=%0b exp=%0b", tag, nm, g, e);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("sdata", sdata, e_sdata);
            chk("dsync", dsync, e_dsync);
            chk("tsync", tsync, e_tsync);
            chk("ovf", ovf, m_ovf);
        end
    end

    task automatic run(input int cycles, input int se, input int be);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            stb    = (se > 0) && (c % se == 0);
            bit_en = (c % be == 0);
            si     = 2'($urandom);
            sq     = 2'($urandom);
        end
    endtask

    task automatic ctl(input int which);
        @(negedge clk);
        stb = 1'b0;
        if (which == 0) start = 1'b1;
        if (which == 1) stop  = 1'b1;
        if (which == 2) srst  = 1'b1;
        if (which == 3) begin start = 1'b1; stop = 1'b1; end
        @(negedge clk);
        start = 1'b0; stop = 1'b0; srst = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag = "R9";          // reset state, idle until start
        run(40, 4, 1);
        tag = "R1 R4 R6";    // lane 1, data-sync marks, time-sync period 128
        lane = 2'd1; dsync_en = 1'b1; tsync_en = 1'b1; period = 15'd128;
        ctl(0);
        run(2200, 8, 1);
        tag = "R5";          // lane 3 with frame-number stamping
        lane = 2'd3; stamp_en = 1'b1;
        run(900, 8, 1);
        tag = "R10";         // sparse bit enables, data-sync off
        lane = 2'd1; dsync_en = 1'b0;
        run(900, 12, 3);
        tag = "R3";          // sample rate above serial rate
        lane = 2'd3; dsync_en = 1'b1;
        run(200, 1, 1);
        tag = "R8";          // stream reset clears everything
        ctl(2);
        run(40, 4, 1);
        tag = "R2";          // reserved lanes ignored, time-sync gated off
        ctl(0);
        tsync_en = 1'b0; period = 15'd200;
        lane = 2'd0; run(300, 2, 1);
        lane = 2'd2; run(300, 2, 1);
        tag = "R7";          // stop halts intake, queue drains
        lane = 2'd1; tsync_en = 1'b1; stamp_en = 1'b0;
        run(1700, 8, 1);
        ctl(1);
        run(400, 8, 1);
        ctl(3);
        run(200, 8, 1);
        ctl(0);
        run(500, 8, 1);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule